// File: doc/BRIEF.md
# Folded AES State Store

This block holds the 128-bit state of an AES engine that processes one 32-bit column per clock. Four cycles make a round. The state sits in four byte-wide row stores. Each cycle, every row supplies one byte, and the four bytes together form the column handed to the round datapath. The read position in each row is offset by the row number, so the byte rotation between rows needed by encryption or by decryption happens through addressing alone. No byte multiplexer network is used.

The processed column comes back on `col_in`. Each of its bytes is written into its own row at the next write position. After four writes, the freshly written positions become the read side for the following round.

A parameter selects the row storage:
- a two-bank ping-pong memory, where the banks swap after four writes; or
- a shift register with a variable read tap, which needs no write address.

A second parameter sets the read-to-write latency of the datapath to zero or one cycle. With one cycle of latency, as with a synchronous S-box, the byte still being written at a round boundary is forwarded straight to the output. This keeps the rate at four cycles per round.

The operating sequence is as follows. First, load the state one column per cycle. Then pulse `start` to run `ROUNDS` rounds. Finally, read the result back one column per cycle in stored order.

Top module: `fold_state_store`

## Requirements
- R1: Bytes are numbered 0 to 15, most significant first. Column c holds bytes 4c to 4c+3, and byte 4c+r belongs to row r. On `col_in` and `col_out`, row r occupies bits [31-8r:24-8r]. While idle, each `load_en` cycle writes `col_in` as the next column, in the order 0, 1, 2, 3. Each `unload_en` cycle presents stored column 0, 1, 2, 3 in turn on `col_out`, unrotated.
- R2: In encryption, read step s (`rd_step`) puts the byte from row r, column (s+r) mod 4 in row r of `col_out`. The steps therefore read bytes (0,5,10,15), (4,9,14,3), (8,13,2,7) and (12,1,6,11).
- R3: In decryption, read step s takes row r from column (s-r) mod 4. The steps therefore read bytes (0,13,10,7), (4,1,14,11), (8,5,2,15) and (12,9,6,3).
- R4: The k-th `col_in` accepted in a round becomes column k of the next round's state. After `ROUNDS` rounds the unloaded state equals the per-round permutation and datapath function applied `ROUNDS` times.
- R5: A run consists of exactly 4*`ROUNDS` consecutive `rd_valid` cycles. `rd_step` counts 0, 1, 2, 3 repeatedly, and `round_idx` counts from 0 to `ROUNDS`-1.
- R6: `wr_take`, the cycle in which `col_in` is captured as a round result, follows each `rd_valid` cycle after exactly `SBOX_LAT` cycles (0 or 1).
- R7: With `SBOX_LAT`=1, at step 0 of every round after the first, the row reading column 3 is served directly from that cycle's `col_in` byte. This is row 3 in encryption and row 1 in decryption.
- R8: While `busy` is high, `start`, `load_en` and `unload_en` have no effect. Row storage changes only in a write cycle.
- R9: The mode is sampled from `decrypt` at `start` and held for the whole run.
- R10: After reset, `busy`, `rd_valid` and `wr_take` are 0, and `col_out` is 0. `busy` is high from the cycle after `start` until the last round write.
- R11: Both row storage variants give identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| decrypt | input | 1 | Mode for the next run: 1 selects decryption addressing |
| start | input | 1 | Begin a run of ROUNDS rounds (idle only) |
| load_en | input | 1 | Write `col_in` as the next state column (idle only) |
| unload_en | input | 1 | Advance to the next stored column on `col_out` (idle only) |
| col_in | input | 32 | Column to load, or processed column from the datapath |
| col_out | output | 32 | Column for the datapath, or the stored column while idle |
| rd_valid | output | 1 | `col_out` carries a round read |
| rd_step | output | 2 | Step within the round of the current read |
| round_idx | output | RND_W | Round number of the current read |
| wr_take | output | 1 | `col_in` is captured as a round result this cycle |
| busy | output | 1 | A run is in progress |

## Verification
The hardest case to reach is the round boundary with a one-cycle datapath. At that point the first column of the new round reads a byte that is only being written in the same cycle, so it has to be forwarded. The bench closes the loop with a registered datapath that adds one to each byte. It runs three rounds in each mode and checks every column read against an independent model of the state. This places the forwarded byte at step 0 of rounds 1 and 2, where a wrong value would also corrupt the unloaded result. A second instance with shift-register rows receives the same stimulus, and its outputs are compared in every check. A disturbance pulse on `start`, `load_en`, `unload_en` and `decrypt` in the middle of a run shows that the run is unaffected.

// File: rtl/fold_state_pkg.sv
package fold_state_pkg;
    localparam int NROWS  = 4;
    localparam int NCOL   = 4;
    localparam int BYTE_W = 8;
    localparam int COL_W  = NROWS * BYTE_W;
    localparam int POS_W  = $clog2(NCOL);
    localparam int DEPTH  = 2 * NCOL;
    localparam int IDX_W  = $clog2(DEPTH);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef enum logic { PH_IDLE, PH_RUN } phase_e;

    // row r of a column sits in the top byte for r = 0
    function automatic byte_t col_byte(input logic [COL_W-1:0] col, input int r);
        return col[COL_W-1-BYTE_W*r -: BYTE_W];
    endfunction
endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl import fold_state_pkg::*; #(
    parameter int ROUNDS   = 10,
    parameter int SBOX_LAT = 1,
    parameter int RND_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       decrypt,
    input  logic                       start,
    input  logic                       load_en,
    input  logic                       unload_en,
    output logic                       wr_en,
    output pos_t                       wr_pos,
    output logic                       wr_bank,
    output logic                       rd_cur,
    output logic [NROWS-1:0][POS_W-1:0] rd_pos,
    output logic                       rd_valid,
    output pos_t                       rd_step,
    output logic [RND_W-1:0]           round_idx,
    output logic                       wr_take,
    output logic                       busy
);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

    typedef struct packed {
        phase_e           phase;
        pos_t             step;
        logic [RND_W-1:0] rnd;
        pos_t             wcnt;
        logic             bank;
        pos_t             idx;
        logic             dec;
        logic             rd_d;
    } ctl_t;

    ctl_t c_q, c_d;
    logic rd_act, pend, busy_w, run_wr, ld_wr, wr_act;

    always_comb begin
        c_d    = c_q;
        rd_act = (c_q.phase == PH_RUN);
        pend   = (SBOX_LAT == 1) ? c_q.rd_d : 1'b0;
        busy_w = rd_act | pend;
        run_wr = (SBOX_LAT == 1) ? c_q.rd_d : rd_act;
        ld_wr  = !busy_w && load_en && !start;
        wr_act = run_wr | ld_wr;

        c_d.rd_d = rd_act;
        if (wr_act) begin
            c_d.wcnt = c_q.wcnt + 1'b1;
            if (c_q.wcnt == pos_t'(NCOL - 1)) c_d.bank = ~c_q.bank;
        end

        if (rd_act) begin
            c_d.step = c_q.step + 1'b1;
            if (c_q.step == pos_t'(NCOL - 1)) begin
                if (c_q.rnd == LAST_RND) c_d.phase = PH_IDLE;
                else                     c_d.rnd   = c_q.rnd + 1'b1;
            end
        end else if (!busy_w) begin
            if (start) begin
                c_d.phase = PH_RUN;
                c_d.step  = '0;
                c_d.rnd   = '0;
                c_d.dec   = decrypt;
                c_d.idx   = '0;
            end else if (unload_en) begin
                c_d.idx = c_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{phase: PH_IDLE, default: '0};
        else        c_q <= c_d;
    end

    // per-row read column: rotation by row number, direction by mode
    for (genvar r = 0; r < NROWS; r++) begin : g_addr
        always_comb begin
            if (!rd_act)    rd_pos[r] = c_q.idx;
            else if (c_q.dec) rd_pos[r] = c_q.step - pos_t'(r);
            else            rd_pos[r] = c_q.step + pos_t'(r);
        end
    end

    // read side still being filled: only at a round boundary with latency
    assign rd_cur    = (SBOX_LAT == 1) && rd_act && run_wr && (c_q.wcnt == pos_t'(NCOL - 1));
    assign wr_en     = wr_act;
    assign wr_pos    = c_q.wcnt;
    assign wr_bank   = c_q.bank;
    assign rd_valid  = rd_act;
    assign rd_step   = c_q.step;
    assign round_idx = c_q.rnd;
    assign wr_take   = run_wr;
    assign busy      = busy_w;

    // R5
    step_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && c_q.step != pos_t'(NCOL - 1)) |=> (rd_act && c_q.step == $past(c_q.step) + 1'b1));
    // R5
    rnd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && c_q.step == pos_t'(NCOL - 1) && c_q.rnd != LAST_RND) |=>
        (rd_act && c_q.rnd == $past(c_q.rnd) + 1'b1));
    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && $past(rd_act)) |-> $stable(c_q.dec));
    // R10
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);
    // R6
    if (SBOX_LAT == 1) begin : g_lat1
        wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |=> wr_take);
    end else begin : g_lat0
        wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> wr_take);
    end
endmodule

// File: rtl/fss_row.sv
module fss_row import fold_state_pkg::*; #(
    parameter int STYLE = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wr_byte,
    input  pos_t  wr_pos,
    input  logic  wr_bank,
    input  pos_t  rd_pos,
    input  logic  rd_cur,
    output byte_t rd_byte
);
    logic [DEPTH-1:0][BYTE_W-1:0] s_q, s_d;
    logic fwd;

    assign fwd = rd_cur && (rd_pos == pos_t'(NCOL - 1));

    if (STYLE == 0) begin : g_pingpong
        logic [IDX_W-1:0] wa, ra;
        always_comb begin
            s_d = s_q;
            wa  = {wr_bank, wr_pos};
            if (wr_en) s_d[wa] = wr_byte;
            ra = rd_cur ? {wr_bank, rd_pos} : {~wr_bank, rd_pos};
        end
        assign rd_byte = fwd ? wr_byte : s_q[ra];
    end else begin : g_shift
        logic [IDX_W-1:0] age, tap;
        logic bank_unused;
        assign bank_unused = wr_bank;
        always_comb begin
            s_d = s_q;
            if (wr_en) begin
                for (int i = DEPTH - 1; i > 0; i--) s_d[i] = s_q[i-1];
                s_d[0] = wr_byte;
            end
            // writes since the read-side column 0 entered the register
            age = rd_cur ? IDX_W'(wr_pos) : IDX_W'(NCOL) + IDX_W'(wr_pos);
            tap = age - IDX_W'(1) - IDX_W'(rd_pos);
        end
        assign rd_byte = fwd ? wr_byte : s_q[tap];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q));
endmodule

// File: rtl/fold_state_store.sv
module fold_state_store import fold_state_pkg::*; #(
    parameter int ROUNDS    = 10,
    parameter int SBOX_LAT  = 1,
    parameter int ROW_STYLE = 0,
    localparam int RND_W    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             decrypt,
    input  logic             start,
    input  logic             load_en,
    input  logic             unload_en,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out,
    output logic             rd_valid,
    output logic [POS_W-1:0] rd_step,
    output logic [RND_W-1:0] round_idx,
    output logic             wr_take,
    output logic             busy
);
    logic wr_en, wr_bank, rd_cur;
    pos_t wr_pos;
    logic [NROWS-1:0][POS_W-1:0] rd_pos;

    fss_ctrl #(.ROUNDS(ROUNDS), .SBOX_LAT(SBOX_LAT), .RND_W(RND_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .decrypt(decrypt), .start(start),
        .load_en(load_en), .unload_en(unload_en),
        .wr_en(wr_en), .wr_pos(wr_pos), .wr_bank(wr_bank), .rd_cur(rd_cur),
        .rd_pos(rd_pos), .rd_valid(rd_valid), .rd_step(rd_step),
        .round_idx(round_idx), .wr_take(wr_take), .busy(busy)
    );

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        byte_t rb;
        fss_row #(.STYLE(ROW_STYLE)) row_i (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
            .wr_byte(col_byte(col_in, r)), .wr_pos(wr_pos), .wr_bank(wr_bank),
            .rd_pos(rd_pos[r]), .rd_cur(rd_cur), .rd_byte(rb)
        );
        assign col_out[COL_W-1-BYTE_W*r -: BYTE_W] = rb;
    end
endmodule

// File: tb/fold_state_store_tb.sv
module fold_state_store_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ROUNDS_TB  = 3;
    localparam int RW         = (ROUNDS_TB > 1) ? $clog2(ROUNDS_TB) : 1;

    logic clk = 0, rst_n = 0;
    logic decrypt = 0, start = 0, load_en = 0, unload_en = 0;
    logic ld_sel = 0;
    logic [31:0] ld_data = '0;
    logic [31:0] dp_a = '0, dp_b = '0;
    logic [31:0] cin_a, cin_b, cout_a, cout_b;
    logic rv_a, rv_b, wt_a, wt_b, busy_a, busy_b;
    logic [1:0] st_a, st_b;
    logic [RW-1:0] ri_a, ri_b;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] inc4(input logic [31:0] v);
        logic [31:0] o;
        for (int r = 0; r < 4; r++) o[31-8*r -: 8] = v[31-8*r -: 8] + 8'd1;
        return o;
    endfunction

    // identity-plus-one datapath with one register (synchronous S-box stand-in)
    always @(posedge clk) begin
        dp_a <= inc4(cout_a);
        dp_b <= inc4(cout_b);
    end
    assign cin_a = ld_sel ? ld_data : dp_a;
    assign cin_b = ld_sel ? ld_data : dp_b;

    fold_state_store #(.ROUNDS(ROUNDS_TB), .SBOX_LAT(1), .ROW_STYLE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .decrypt(decrypt), .start(start), .load_en(load_en),
        .unload_en(unload_en), .col_in(cin_a), .col_out(cout_a), .rd_valid(rv_a),
        .rd_step(st_a), .round_idx(ri_a), .wr_take(wt_a), .busy(busy_a));

    fold_state_store #(.ROUNDS(ROUNDS_TB), .SBOX_LAT(1), .ROW_STYLE(1)) dut_sr_i (
        .clk(clk), .rst_n(rst_n), .decrypt(decrypt), .start(start), .load_en(load_en),
        .unload_en(unload_en), .col_in(cin_b), .col_out(cout_b), .rd_valid(rv_b),
        .rd_step(st_b), .round_idx(ri_b), .wr_take(wt_b), .busy(busy_b));

    function automatic logic [7:0] sb(input logic [127:0] s, input int r, input int c);
        return s[127-8*(4*c+r) -: 8];
    endfunction
    function automatic logic [31:0] colof(input logic [127:0] s, input int c);
        return s[127-32*c -: 32];
    endfunction
    function automatic logic [31:0] grp(input logic [127:0] s, input int st, input bit dec);
        logic [31:0] o;
        for (int r = 0; r < 4; r++) o[31-8*r -: 8] = sb(s, r, dec ? ((st - r) & 3) : ((st + r) & 3));
        return o;
    endfunction
    function automatic logic [127:0] next_state(input logic [127:0] s, input bit dec);
        logic [127:0] o;
        for (int c = 0; c < 4; c++) o[127-32*c -: 32] = inc4(grp(s, c, dec));
        return o;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R10 reset busy", {30'd0, busy_a, busy_b}, 32'd0);
        check("R10 reset rd_valid/wr_take", {28'd0, rv_a, rv_b, wt_a, wt_b}, 32'd0);
        check("R10 reset col_out", cout_a | cout_b, 32'd0);
    endtask

    task automatic load_state(input logic [127:0] s);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            ld_sel = 1; ld_data = colof(s, c); load_en = 1;
        end
        @(negedge clk);
        load_en = 0; ld_sel = 0;
    endtask

    task automatic unload_check(input string req, input logic [127:0] s);
        for (int c = 0; c < 4; c++) begin
            if (c > 0) @(negedge clk);
            unload_en = 1;
            #1;
            check(req, cout_a, colof(s, c));
            check("R11 shift-row variant unload", cout_b, colof(s, c));
        end
        @(negedge clk);
        unload_en = 0;
    endtask

    // R1: load then unload in stored order
    task automatic t_load_unload(input logic [127:0] s);
        load_state(s);
        unload_check("R1 load/unload column", s);
    endtask

    // R2/R3/R4/R5/R6/R7/R8/R9: full run with an incrementing datapath
    task automatic t_run(input logic [127:0] s, input bit dec, input bit disturb);
        logic [127:0] cur;
        int nread;
        bit prev_rv;
        string req;
        load_state(s);
        cur = s; nread = 0; prev_rv = 0;
        decrypt = dec; start = 1;
        @(negedge clk);
        start = 0;
        for (int cyc = 0; cyc < 4*ROUNDS_TB + 3; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (disturb && cyc == 6) begin
                start = 1; load_en = 1; unload_en = 1; decrypt = ~dec;
            end else begin
                start = 0; load_en = 0; unload_en = 0; decrypt = dec;
            end
            #1;
            check("R6 wr_take follows read", {31'd0, wt_a}, {31'd0, prev_rv});
            if (rv_a) begin
                req = (nread % 4 == 0 && nread > 0) ? "R7 forwarded column" : (dec ? "R3 dec read group" : "R2 enc read group");
                check(req, cout_a, grp(cur, nread % 4, dec));
                check("R11 variant col_out", cout_b, cout_a);
                check("R5 step/round", {28'd0, st_a, 2'(ri_a)}, {28'd0, 2'(nread % 4), 2'(nread / 4)});
                nread++;
                if (nread % 4 == 0) cur = next_state(cur, dec);
            end
            prev_rv = rv_a;
        end
        start = 0; load_en = 0; unload_en = 0;
        check("R5 read count", nread, 4*ROUNDS_TB);
        check("R10 busy after run", {31'd0, busy_a | busy_b}, 32'd0);
        unload_check(disturb ? "R8 R9 result after disturbance" : "R4 result state", cur);
    endtask

    initial begin
        t_reset();
        t_load_unload(128'h00112233_44556677_8899aabb_ccddeeff);
        t_run(128'h000102030405060708090a0b0c0d0e0f, 1'b0, 1'b0);
        t_run(128'h000102030405060708090a0b0c0d0e0f, 1'b1, 1'b0);
        t_run(128'h3243f6a8_885a308d_313198a2_e0370734, 1'b0, 1'b1);
        t_run(128'hf0e1d2c3_b4a59687_78695a4b_3c2d1e0f, 1'b1, 1'b1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule